// File: doc/BRIEF.md
# Packet DMA Channel Control and Status

This block is the control and status logic for one channel of a packet DMA engine. The channel sits between a device endpoint that offers data beats and a memory-side sink. Software programs the channel through a two-word register port. The control word holds an enable, a load-next-descriptor option and a buffer byte count. The status word reports whether the channel is enabled and whether it is actively sourcing a packet, along with two sticky completion flags, a descriptor-loaded flag and the bytes still remaining in the buffer.

Accepted beats go into a small FIFO, and that FIFO drains one word per cycle toward memory. A transfer ends when the byte count runs out or when the device marks the last beat of a packet as the end of the transfer. At that point the channel disables itself. If load-next is set, it then requests the next descriptor. The descriptor word has the same layout as the control word and takes effect exactly like a control write. If software clears the enable while data is still buffered, the enable status stays up until the FIFO has emptied. A chip with several channels instantiates this block once per channel.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset every status bit is 0. The status word (reg_addr=1) is laid out as follows: enabled at bit 0, active at bit 1, end-of-transfer at bit 4, end-of-buffer at bit 5, descriptor-loaded at bit 6, remaining count at bits 31:16, and all other bits 0. The control readback (reg_addr=0) carries the enable at bit 0 and load-next at bit 1, with all other bits 0.
- R2: A control write (reg_wr, reg_addr=0) sets the enable from bit 0 and load-next from bit 1. When bit 0 is 1, the write also loads the count from bits 31:16 and sets the enable status, and every control write clears descriptor-loaded. ep_ack is high only when all of these hold: ep_req is high, both enable control and enable status are set, no control write is happening in that cycle, no descriptor is pending and the FIFO is not full.
- R3: Each accepted beat lowers the count by ep_bytes, and the count saturates at 0.
- R4: An accepted beat that brings the count to 0 ends the transfer. So does a beat that has both ep_pkt_end and ep_dev_end set. When a transfer ends, enable control and enable status are both 0 on the next cycle.
- R5: After software clears the enable, the enable status holds while the FIFO holds data. It clears in the cycle after the FIFO is seen empty.
- R6: When the enable status falls while load-next is set, dsc_req rises and stays high until dsc_valid. The dsc_word is then applied as a control write would be, and descriptor-loaded is set.
- R7: An accepted beat without ep_pkt_end sets the active flag. An accepted beat with ep_pkt_end clears it.
- R8: If the count reaches 0 in the middle of a packet while load-next is set, the active flag stays set through the descriptor reload. The flag clears if the new descriptor has enable 0, if load-next was 0 when the count hit 0, or when a software disable finishes draining.
- R9: The end-of-buffer flag sets on the beat that brings the count to 0. The end-of-transfer flag sets on a beat that has both ep_pkt_end and ep_dev_end.
- R10: A status read (reg_rd, reg_addr=1) clears both end flags on the next cycle. If a new end event falls in the same cycle as the read, that flag stays set.
- R11: The FIFO holds 4 words and keeps them in order. mem_valid and mem_data show the oldest word, which is popped on each cycle with mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| ep_req | input | 1 | Endpoint offers a beat |
| ep_data | input | DATA_W | Beat data |
| ep_bytes | input | BYTES_W | Bytes in the beat |
| ep_pkt_end | input | 1 | Beat is last of a packet |
| ep_dev_end | input | 1 | Device ends the transfer with this packet |
| ep_ack | output | 1 | Beat accepted |
| mem_valid | output | 1 | FIFO word available |
| mem_data | output | DATA_W | Oldest FIFO word |
| mem_ready | input | 1 | Memory side takes the word |
| dsc_req | output | 1 | Next descriptor requested |
| dsc_valid | input | 1 | Descriptor word present |
| dsc_word | input | 32 | Descriptor word, control layout |

## Verification
The critical coincidence is a status read that falls in the same cycle as a new end event. The read would clear the flag while the event would set it. The bench lines up a read with the beat that empties the buffer, and with a device-end beat. It then checks that the flag is still set on the next cycle, and that a later read with no event clears it. A second overlap is the buffer running out in the middle of a packet while a descriptor reload is pending. Here the active flag is checked on every cycle against a behavioural model, from the moment the flag is set, through the reload and up to the closing packet-end beat.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CNT_W = 16;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [CNT_W-1:0]          cnt;
    logic [WORD_W-CNT_W-3:0]   rsv;
    logic                      ldnxt;
    logic                      en;
  } ctl_word_t;

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [CNT_W-1:0] cnt,
                                                    input logic ldd, input logic bf,
                                                    input logic tr, input logic act,
                                                    input logic en);
    return {cnt, 9'b0, ldd, bf, tr, 2'b0, act, en};
  endfunction
endpackage

// File: rtl/dma_chan_fifo.sv
module dma_chan_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       fill;
  logic              do_pop;

  assign full   = (fill == (AW+1)'(DEPTH));
  assign empty  = (fill == '0);
  assign do_pop = pop && !empty;
  assign rdata  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + (AW+1)'(push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/dma_chan_flag.sv
module dma_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
  import dma_chan_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int BYTES_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               ep_req,
  input  logic [DATA_W-1:0]  ep_data,
  input  logic [BYTES_W-1:0] ep_bytes,
  input  logic               ep_pkt_end,
  input  logic               ep_dev_end,
  output logic               ep_ack,
  output logic               mem_valid,
  output logic [DATA_W-1:0]  mem_data,
  input  logic               mem_ready,
  output logic               dsc_req,
  input  logic               dsc_valid,
  input  logic [WORD_W-1:0]  dsc_word
);
  logic              en_ctl, en_ctl_n;
  logic              ldnxt, ldnxt_n;
  logic              en_stat, en_stat_n;
  logic              act, act_n;
  logic              ldd, ldd_n;
  logic              dsc_pend, dsc_pend_n;
  logic [CNT_W-1:0]  cnt, cnt_n, cnt_dec;
  logic              fifo_full, fifo_empty;
  logic              st_bf, st_tr;

  // named internal events
  logic ctl_wr, st_rd, bf_evt, tr_evt, end_evt, drain_done, dsc_take, en_fall;
  ctl_word_t wr_w, ds_w;

  assign wr_w       = ctl_word_t'(reg_wdata);
  assign ds_w       = ctl_word_t'(dsc_word);
  assign ctl_wr     = reg_wr && !reg_addr;
  assign st_rd      = reg_rd && reg_addr;
  assign ep_ack     = ep_req && en_ctl && en_stat && !ctl_wr && !dsc_pend && !fifo_full;
  assign cnt_dec    = sat_sub(cnt, CNT_W'(ep_bytes));
  assign bf_evt     = ep_ack && (cnt_dec == '0);
  assign tr_evt     = ep_ack && ep_pkt_end && ep_dev_end;
  assign end_evt    = bf_evt || tr_evt;
  assign drain_done = en_stat && !en_ctl && fifo_empty;
  assign dsc_take   = dsc_pend && dsc_valid;
  assign en_fall    = en_stat && !en_stat_n;
  assign dsc_req    = dsc_pend;
  assign mem_valid  = !fifo_empty;

  always_comb begin
    en_ctl_n   = en_ctl;
    ldnxt_n    = ldnxt;
    en_stat_n  = en_stat;
    act_n      = act;
    ldd_n      = ldd;
    cnt_n      = cnt;
    dsc_pend_n = dsc_pend;
    if (ep_ack) begin
      cnt_n = cnt_dec;
      act_n = !ep_pkt_end && !(bf_evt && !ldnxt);
    end
    if (end_evt) begin
      en_ctl_n  = 1'b0;
      en_stat_n = 1'b0;
    end
    if (drain_done) begin
      en_stat_n = 1'b0;
      act_n     = 1'b0;
    end
    if (ctl_wr) begin
      en_ctl_n = wr_w.en;
      ldnxt_n  = wr_w.ldnxt;
      ldd_n    = 1'b0;
      if (wr_w.en) begin
        cnt_n     = wr_w.cnt;
        en_stat_n = 1'b1;
      end
    end
    if (dsc_take) begin
      en_ctl_n   = ds_w.en;
      ldnxt_n    = ds_w.ldnxt;
      ldd_n      = 1'b1;
      dsc_pend_n = 1'b0;
      act_n      = act && ds_w.en;
      if (ds_w.en) begin
        cnt_n     = ds_w.cnt;
        en_stat_n = 1'b1;
      end
    end
    if (en_stat && !en_stat_n && ldnxt_n) dsc_pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ctl   <= 1'b0;
      ldnxt    <= 1'b0;
      en_stat  <= 1'b0;
      act      <= 1'b0;
      ldd      <= 1'b0;
      cnt      <= '0;
      dsc_pend <= 1'b0;
    end else begin
      en_ctl   <= en_ctl_n;
      ldnxt    <= ldnxt_n;
      en_stat  <= en_stat_n;
      act      <= act_n;
      ldd      <= ldd_n;
      cnt      <= cnt_n;
      dsc_pend <= dsc_pend_n;
    end
  end

  dma_chan_flag u_bf (.clk(clk), .rst_n(rst_n), .set(bf_evt), .clr(st_rd), .q(st_bf));
  dma_chan_flag u_tr (.clk(clk), .rst_n(rst_n), .set(tr_evt), .clr(st_rd), .q(st_tr));

  dma_chan_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ep_ack), .wdata(ep_data),
    .pop(mem_ready), .rdata(mem_data), .full(fifo_full), .empty(fifo_empty)
  );

  assign reg_rdata = reg_addr ? pack_status(cnt, ldd, st_bf, st_tr, act, en_stat)
                              : {{(WORD_W-2){1'b0}}, ldnxt, en_ctl};
endmodule

// File: rtl/dma_chan_stat_chk.sv
module dma_chan_stat_chk #(parameter int DATA_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic              ep_ack,
  input logic              ep_pkt_end,
  input logic              bf_evt,
  input logic              tr_evt,
  input logic              end_evt,
  input logic              en_stat,
  input logic              en_ctl,
  input logic              fifo_empty,
  input logic              act,
  input logic              st_bf,
  input logic              st_tr,
  input logic              dsc_req,
  input logic              dsc_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_data
);
  // R4
  end_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!en_stat && !en_ctl));
  // R5
  drain_holds_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stat && !en_ctl && !fifo_empty) |=> en_stat);
  // R6
  dsc_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && !dsc_valid) |=> dsc_req);
  // R7
  pkt_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_ack && ep_pkt_end) |=> !act);
  // R10
  bf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bf_evt |=> st_bf);
  // R10
  tr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_evt |=> st_tr);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)));
endmodule

bind dma_chan_stat dma_chan_stat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_ack(ep_ack), .ep_pkt_end(ep_pkt_end),
  .bf_evt(bf_evt), .tr_evt(tr_evt), .end_evt(end_evt), .en_stat(en_stat),
  .en_ctl(en_ctl), .fifo_empty(fifo_empty), .act(act), .st_bf(st_bf),
  .st_tr(st_tr), .dsc_req(dsc_req), .dsc_valid(dsc_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data)
);

// File: tb/sim_dma_chan_stat.sv
`timescale 1ns/1ps
module sim_dma_chan_stat;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0, reg_addr = 1;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        ep_req = 0, ep_pkt_end = 0, ep_dev_end = 0, ep_ack;
  logic [31:0] ep_data = 0;
  logic [2:0]  ep_bytes = 4;
  logic        mem_valid, mem_ready = 0, dsc_req, dsc_valid = 0;
  logic [31:0] mem_data, dsc_word = 0;

  always #5 clk = ~clk;

  dma_chan_stat u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_enc = 0, m_ld = 0, m_en = 0, m_act = 0, m_tr = 0, m_bf = 0, m_ldd = 0, m_pend = 0;
  int m_cnt = 0;
  logic [31:0] m_q[$];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic bit m_ack();
    return ep_req && m_enc && m_en && !(reg_wr && !reg_addr) && !m_pend && (m_q.size() < 4);
  endfunction

  task automatic tick();
    bit ack, bfe, tre, endev, dd, old_en, pop;
    int nc;
    logic [31:0] ds;
    #1;
    ack = m_ack();
    chk("R2 ack", 32'(ep_ack), 32'(ack));
    chk("R6 dsc_req", 32'(dsc_req), 32'(m_pend));
    chk("R11 mem_valid", 32'(mem_valid), 32'(m_q.size() > 0));
    if (m_q.size() > 0) chk("R11 mem_data", mem_data, m_q[0]);
    if (reg_addr) begin
      chk("R4 en", 32'(reg_rdata[0]), 32'(m_en));
      chk("R7 act", 32'(reg_rdata[1]), 32'(m_act));
      chk("R9 tr", 32'(reg_rdata[4]), 32'(m_tr));
      chk("R9 bf", 32'(reg_rdata[5]), 32'(m_bf));
      chk("R6 ldd", 32'(reg_rdata[6]), 32'(m_ldd));
      chk("R3 cnt", 32'(reg_rdata[31:16]), m_cnt);
      chk("R1 zero bits", 32'(reg_rdata[15:7]) | 32'(reg_rdata[3:2]), 0);
    end else
      chk("R1 ctl", reg_rdata, {30'b0, m_ld, m_enc});
    @(posedge clk);
    cyc++;
    old_en = m_en;
    pop = mem_ready && m_q.size() > 0;
    dd = m_en && !m_enc && m_q.size() == 0;
    nc = (m_cnt > ep_bytes) ? m_cnt - ep_bytes : 0;
    bfe = ack && nc == 0;
    tre = ack && ep_pkt_end && ep_dev_end;
    endev = bfe || tre;
    m_tr = tre || (m_tr && !(reg_rd && reg_addr));
    m_bf = bfe || (m_bf && !(reg_rd && reg_addr));
    if (pop) void'(m_q.pop_front());
    if (ack) begin
      m_q.push_back(ep_data);
      m_cnt = nc;
      m_act = !ep_pkt_end && !(bfe && !m_ld);
    end
    if (endev) begin m_enc = 0; m_en = 0; end
    if (dd) begin m_en = 0; m_act = 0; end
    if (reg_wr && !reg_addr) begin
      m_enc = reg_wdata[0]; m_ld = reg_wdata[1]; m_ldd = 0;
      if (reg_wdata[0]) begin m_cnt = reg_wdata[31:16]; m_en = 1; end
    end
    if (m_pend && dsc_valid) begin
      ds = dsc_word;
      m_enc = ds[0]; m_ld = ds[1]; m_ldd = 1; m_pend = 0; m_act = m_act && ds[0];
      if (ds[0]) begin m_cnt = ds[31:16]; m_en = 1; end
    end
    if (old_en && !m_en && m_ld) m_pend = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; reg_addr = 1; ep_req = 0; ep_pkt_end = 0;
    ep_dev_end = 0; dsc_valid = 0; ep_bytes = 4;
  endtask

  task automatic wr_ctl(int cnt, bit ld, bit en);
    idle(); reg_wr = 1; reg_addr = 0; reg_wdata = {16'(cnt), 14'b0, ld, en};
    tick(); idle();
  endtask

  task automatic beat(int bytes, bit pe, bit de);
    idle(); ep_req = 1; ep_bytes = 3'(bytes); ep_pkt_end = pe; ep_dev_end = de;
    ep_data = ep_data + 1; tick(); idle();
  endtask

  always @(posedge clk) begin
    if (rst_n && cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk); @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 reset status", reg_rdata, 32'h0);
    tick();
    // R2 R11 fill FIFO with memory stalled, then drain
    wr_ctl(100, 0, 1);
    for (int i = 0; i < 6; i++) beat(4, 0, 0);
    chk("R11 stalled at full", 32'(u0.ep_ack), 0);
    mem_ready = 1;
    for (int i = 0; i < 5; i++) tick();
    // R7 packet end clears active
    beat(2, 0, 0); beat(3, 1, 0); tick();
    // R5 software disable drains first
    mem_ready = 0;
    beat(4, 0, 0); beat(4, 0, 0);
    wr_ctl(0, 0, 0);
    for (int i = 0; i < 3; i++) tick();
    mem_ready = 1;
    for (int i = 0; i < 4; i++) tick();
    // R8 R6 buffer end mid packet with reload; read coincides with event (R10)
    wr_ctl(6, 1, 1);
    beat(4, 0, 0);
    idle(); ep_req = 1; ep_bytes = 4; reg_rd = 1; ep_data = ep_data + 1; tick(); idle();
    for (int i = 0; i < 3; i++) tick();
    idle(); dsc_valid = 1; dsc_word = {16'd8, 14'b0, 1'b0, 1'b1}; tick(); idle();
    beat(4, 1, 0); tick();
    // R10 read clears
    idle(); reg_rd = 1; tick(); idle(); tick();
    // R9 device end, read in the same cycle
    wr_ctl(50, 0, 1);
    beat(4, 0, 0);
    idle(); ep_req = 1; ep_pkt_end = 1; ep_dev_end = 1; reg_rd = 1; ep_data = ep_data + 1;
    tick(); idle(); tick();
    // R8 buffer end with no load-next clears active
    wr_ctl(3, 0, 1);
    beat(4, 0, 0); tick();
    // R8 reload with enable 0 clears active
    wr_ctl(2, 1, 1);
    beat(2, 0, 0); tick();
    idle(); dsc_valid = 1; dsc_word = 32'h0; tick(); idle();
    for (int i = 0; i < 3; i++) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule